// File: doc/BRIEF.md
# UART Automatic Modem Flow Controller

This block sits next to a UART transmit shifter and a receive FIFO and handles hardware handshaking without software help. On the request side it drives an active-low request output from the receive FIFO fill level. It raises the output (halt) when the count reaches a halt threshold. It lowers it again only once the count has dropped to a lower resume threshold or below it, so the output has hysteresis.

On the clear side it watches the remote active-low clear input through a two-flop synchronizer. When that input goes HIGH, the block holds off the transmitter, but only at a character boundary, so a character already being shifted finishes first. Transmission resumes once the input returns LOW.

A single select bit chooses which pin pair is used: the request-to-send / clear-to-send pair or the terminal-ready / set-ready pair. Deassertion of either selected pin can raise a flow-control interrupt. Software clears that interrupt by reading the modem status. Control arrives as three register images: a feature register, a modem-control register and an interrupt-enable register.

Top module: `uart_autoflow`

## Requirements
- R1: While reset is applied and after it is released, with all control inputs zero, both request outputs are HIGH and tx_hold, irq and fc_status are 0.
- R2: With automatic request control off (feat_ctl bit 6 = 0), rts_n equals the inverse of mdm_ctl bit 0 and dtr_n equals the inverse of mdm_ctl bit 1.
- R3: With feat_ctl bit 6 = 1 and the manual bit of the selected pair set, the selected request output goes HIGH one cycle after rx_count >= halt_lvl. It stays HIGH while rx_count is above resume_lvl, and goes LOW one cycle after rx_count <= resume_lvl.
- R4: Automatic request control is inert until software sets the selected manual bit. While that bit is 0 the output stays HIGH and no halt is remembered, so setting the bit with the count between the thresholds gives a LOW output.
- R5: mdm_ctl bit 2 selects the pair: 0 picks rts_n with cts_n, and 1 picks dtr_n with dsr_n. The unselected request output follows only its manual bit, and the unselected clear input has no effect on tx_hold.
- R6: With feat_ctl bit 7 = 1, a HIGH on the selected clear input raises tx_hold three clock edges after the pin changes, provided tx_busy is 0. If tx_busy is 1, tx_hold rises one cycle after tx_busy falls, and never while a character is in flight.
- R7: When the selected clear input returns LOW, tx_hold falls three clock edges after the pin change.
- R8: With feat_ctl bit 7 = 0, tx_hold stays 0 whatever the clear inputs do.
- R9: A LOW-to-HIGH change of the synchronized selected clear input, with feat_ctl bit 4 = 1 and irq_en bit 7 = 1, sets fc_status and irq. A LOW-to-HIGH change of the selected request output, with feat_ctl bit 4 = 1 and irq_en bit 6 = 1, does the same one cycle after the output rises.
- R10: With feat_ctl bit 4 = 0, no flow-control event sets fc_status.
- R11: A one-cycle pulse on msr_rd clears fc_status and irq on the next edge, unless a new event arrives in that same cycle.
- R12: irq is the OR of each pending source ANDed with its current enable. Dropping an enable removes irq while fc_status stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_ctl | input | 8 | Feature register image: bit 7 auto clear, bit 6 auto request, bit 4 interrupt master enable |
| mdm_ctl | input | 3 | Bit 0 manual RTS assert, bit 1 manual DTR assert, bit 2 pair select |
| irq_en | input | 8 | Bit 7 clear-side interrupt enable, bit 6 request-side interrupt enable |
| halt_lvl | input | CNT_W | Receive count at which the request output is deasserted |
| resume_lvl | input | CNT_W | Receive count at or below which the request output is reasserted |
| rx_count | input | CNT_W | Current receive FIFO fill level |
| cts_n | input | 1 | Remote clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Remote set-ready, active low, asynchronous |
| tx_busy | input | 1 | High while the shifter is sending a character through its stop bit |
| msr_rd | input | 1 | One-cycle pulse when software reads modem status |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| tx_hold | output | 1 | Do not start a new character |
| fc_status | output | 1 | Flow-control interrupt status |
| irq | output | 1 | Flow-control interrupt request |

## Verification
The assertions assume that tx_busy is driven by a shifter that only begins a character while tx_hold is low. They also assume that msr_rd is a single-cycle pulse. The clear pins may change at any time, but checks use their synchronized values, so the checker makes no assumption about when a pin changes relative to the clock. The bench changes every input half a cycle away from the active edge. It keeps the halt threshold above the resume threshold and pulses msr_rd for exactly one cycle.

// File: rtl/uart_autoflow_pkg.sv
package uart_autoflow_pkg;
  localparam int FEAT_AUTO_CLR = 7;
  localparam int FEAT_AUTO_REQ = 6;
  localparam int FEAT_IRQ_GLB  = 4;
  localparam int MDM_MAN_RTS   = 0;
  localparam int MDM_MAN_DTR   = 1;
  localparam int MDM_PAIR_SEL  = 2;
  localparam int IEN_CLR       = 7;
  localparam int IEN_REQ       = 6;

  typedef enum logic {
    PAIR_RTS_CTS = 1'b0,
    PAIR_DTR_DSR = 1'b1
  } pair_e;
endpackage

// File: rtl/uart_autoflow_sync.sv
module uart_autoflow_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (s == 0) begin : g_first
        assign src = d_async;
      end else begin : g_next
        assign src = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= src;
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/uart_autoflow_req.sv
module uart_autoflow_req
  import uart_autoflow_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  pair_e            pair,
  input  logic             man_rts,
  input  logic             man_dtr,
  input  logic [CNT_W-1:0] halt_lvl,
  input  logic [CNT_W-1:0] resume_lvl,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             req_sel_n
);
  logic halted_q, halted_d;
  logic active;
  logic sel_dtr;

  assign sel_dtr = (pair == PAIR_DTR_DSR);
  assign active  = auto_en & (sel_dtr ? man_dtr : man_rts);

  always_comb begin
    halted_d = halted_q;
    if (!active)                    halted_d = 1'b0;
    else if (rx_count >= halt_lvl)  halted_d = 1'b1;
    else if (rx_count <= resume_lvl) halted_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else        halted_q <= halted_d;
  end

  assign rts_n     = ~man_rts | (halted_q & active & ~sel_dtr);
  assign dtr_n     = ~man_dtr | (halted_q & active &  sel_dtr);
  assign req_sel_n = sel_dtr ? dtr_n : rts_n;
endmodule

// File: rtl/uart_autoflow_txgate.sv
module uart_autoflow_txgate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic clr_sel,
  input  logic tx_busy,
  output logic tx_hold
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!auto_en || !clr_sel) hold_d = 1'b0;
    else if (!tx_busy)        hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign tx_hold = hold_q;
endmodule

// File: rtl/uart_autoflow_irq.sv
module uart_autoflow_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic glb_en,
  input  logic clr_en,
  input  logic req_en,
  input  logic clr_sel,
  input  logic req_sel_n,
  input  logic msr_rd,
  output logic fc_status,
  output logic irq
);
  logic clr_prev_q, req_prev_q;
  logic st_clr_q, st_clr_d;
  logic st_req_q, st_req_d;
  logic set_clr, set_req;

  assign set_clr = glb_en & clr_en & clr_sel & ~clr_prev_q;
  assign set_req = glb_en & req_en & req_sel_n & ~req_prev_q;

  always_comb begin
    st_clr_d = st_clr_q;
    st_req_d = st_req_q;
    if (msr_rd) begin
      st_clr_d = 1'b0;
      st_req_d = 1'b0;
    end
    if (set_clr) st_clr_d = 1'b1;
    if (set_req) st_req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_prev_q <= 1'b0;
      req_prev_q <= 1'b1;
      st_clr_q   <= 1'b0;
      st_req_q   <= 1'b0;
    end else begin
      clr_prev_q <= clr_sel;
      req_prev_q <= req_sel_n;
      st_clr_q   <= st_clr_d;
      st_req_q   <= st_req_d;
    end
  end

  assign fc_status = st_clr_q | st_req_q;
  assign irq       = glb_en & ((st_clr_q & clr_en) | (st_req_q & req_en));
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import uart_autoflow_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       feat_ctl,
  input  logic [2:0]       mdm_ctl,
  input  logic [7:0]       irq_en,
  input  logic [CNT_W-1:0] halt_lvl,
  input  logic [CNT_W-1:0] resume_lvl,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             tx_busy,
  input  logic             msr_rd,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             tx_hold,
  output logic             fc_status,
  output logic             irq
);
  localparam int SYNC_STAGES = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic [1:0] clr_sync;
  logic       clr_sel;
  logic       req_sel_n;
  pair_e      pair;
  logic       unused_bits;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign pair = pair_e'(mdm_ctl[MDM_PAIR_SEL]);
  assign unused_bits = ^{feat_ctl[5], feat_ctl[3:0], irq_en[5:0]};

  uart_autoflow_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async ({dsr_n, cts_n}),
    .q_sync  (clr_sync)
  );

  assign clr_sel = (pair == PAIR_DTR_DSR) ? clr_sync[1] : clr_sync[0];

  uart_autoflow_req #(.CNT_W(CNT_W)) i_req (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .auto_en    (feat_ctl[FEAT_AUTO_REQ]),
    .pair       (pair),
    .man_rts    (mdm_ctl[MDM_MAN_RTS]),
    .man_dtr    (mdm_ctl[MDM_MAN_DTR]),
    .halt_lvl   (halt_lvl),
    .resume_lvl (resume_lvl),
    .rx_count   (rx_count),
    .rts_n      (rts_n),
    .dtr_n      (dtr_n),
    .req_sel_n  (req_sel_n)
  );

  uart_autoflow_txgate i_gate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .auto_en (feat_ctl[FEAT_AUTO_CLR]),
    .clr_sel (clr_sel),
    .tx_busy (tx_busy),
    .tx_hold (tx_hold)
  );

  uart_autoflow_irq i_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .glb_en    (feat_ctl[FEAT_IRQ_GLB]),
    .clr_en    (irq_en[IEN_CLR]),
    .req_en    (irq_en[IEN_REQ]),
    .clr_sel   (clr_sel),
    .req_sel_n (req_sel_n),
    .msr_rd    (msr_rd),
    .fc_status (fc_status),
    .irq       (irq)
  );
endmodule

// File: rtl/uart_autoflow_chk.sv
module uart_autoflow_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] feat_ctl,
  input logic [2:0] mdm_ctl,
  input logic       tx_busy,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       tx_hold,
  input logic       fc_status,
  input logic       irq
);
  // R8: auto clear off means the transmitter is released next cycle
  assert_clr_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_ctl[7] |=> !tx_hold);

  // R6: hold only starts at a character boundary
  assert_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> !$past(tx_busy));

  // R12: an interrupt always has a pending status behind it
  assert_irq_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fc_status);

  // R10: status only rises with the master enable set
  assert_master_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fc_status) |-> $past(feat_ctl[4]));

  // R4: without the manual bit the request stays deasserted
  assert_manual_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdm_ctl[0] |-> rts_n) and (!mdm_ctl[1] |-> dtr_n));

  // R2: without auto request the outputs follow the manual bits
  assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_ctl[6] |-> (rts_n == !mdm_ctl[0]) && (dtr_n == !mdm_ctl[1]));
endmodule

bind uart_autoflow uart_autoflow_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .feat_ctl  (feat_ctl),
  .mdm_ctl   (mdm_ctl),
  .tx_busy   (tx_busy),
  .rts_n     (rts_n),
  .dtr_n     (dtr_n),
  .tx_hold   (tx_hold),
  .fc_status (fc_status),
  .irq       (irq)
);

// File: tb/test_uart_autoflow.sv
`timescale 1ns/1ps
module test_uart_autoflow;
  localparam int CNT_W = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       feat_ctl;
  logic [2:0]       mdm_ctl;
  logic [7:0]       irq_en;
  logic [CNT_W-1:0] halt_lvl, resume_lvl, rx_count;
  logic             cts_n, dsr_n, tx_busy, msr_rd;
  logic             rts_n, dtr_n, tx_hold, fc_status, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  uart_autoflow #(.CNT_W(CNT_W)) i_uart_autoflow (
    .clk(clk), .rst_n(rst_n), .feat_ctl(feat_ctl), .mdm_ctl(mdm_ctl),
    .irq_en(irq_en), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
    .rx_count(rx_count), .cts_n(cts_n), .dsr_n(dsr_n), .tx_busy(tx_busy),
    .msr_rd(msr_rd), .rts_n(rts_n), .dtr_n(dtr_n), .tx_hold(tx_hold),
    .fc_status(fc_status), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; feat_ctl = '0; mdm_ctl = '0; irq_en = '0;
    halt_lvl = 9'd200; resume_lvl = 9'd100; rx_count = '0;
    cts_n = 1'b0; dsr_n = 1'b0; tx_busy = 1'b0; msr_rd = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rts_n", rts_n, 1'b1);
    check("R1 dtr_n", dtr_n, 1'b1);
    check("R1 tx_hold", tx_hold, 1'b0);
    check("R1 irq", irq, 1'b0);
    check("R1 fc_status", fc_status, 1'b0);
  endtask

  task automatic t_manual();
    do_reset();
    mdm_ctl = 3'b001; rx_count = 9'd300; tick(1);
    check("R2 rts low", rts_n, 1'b0);
    check("R2 dtr high", dtr_n, 1'b1);
    mdm_ctl = 3'b010; tick(1);
    check("R2 rts high", rts_n, 1'b1);
    check("R2 dtr low", dtr_n, 1'b0);
  endtask

  task automatic t_hyst();
    do_reset();
    feat_ctl = 8'h40; mdm_ctl = 3'b001; rx_count = 9'd199; tick(1);
    check("R3 below halt", rts_n, 1'b0);
    rx_count = 9'd200; tick(1);
    check("R3 at halt", rts_n, 1'b1);
    rx_count = 9'd150; tick(1);
    check("R3 in band", rts_n, 1'b1);
    rx_count = 9'd101; tick(1);
    check("R3 above resume", rts_n, 1'b1);
    rx_count = 9'd100; tick(1);
    check("R3 at resume", rts_n, 1'b0);
    rx_count = 9'd150; tick(1);
    check("R3 band from below", rts_n, 1'b0);
  endtask

  task automatic t_inert();
    do_reset();
    feat_ctl = 8'h40; mdm_ctl = 3'b000; rx_count = 9'd250; tick(2);
    check("R4 inert high", rts_n, 1'b1);
    rx_count = 9'd150; mdm_ctl = 3'b001; tick(1);
    check("R4 no stale halt", rts_n, 1'b0);
  endtask

  task automatic t_pair();
    do_reset();
    feat_ctl = 8'h40; mdm_ctl = 3'b110; rx_count = 9'd200; tick(1);
    check("R5 dtr auto halt", dtr_n, 1'b1);
    mdm_ctl = 3'b111; tick(1);
    check("R5 rts manual only", rts_n, 1'b0);
    check("R5 dtr still halted", dtr_n, 1'b1);
    feat_ctl = 8'h80; mdm_ctl = 3'b100; cts_n = 1'b1; dsr_n = 1'b0; tick(3);
    check("R5 cts ignored", tx_hold, 1'b0);
    dsr_n = 1'b1; tick(3);
    check("R5 dsr gates", tx_hold, 1'b1);
  endtask

  task automatic t_gate();
    do_reset();
    feat_ctl = 8'h80; cts_n = 1'b1; tick(2);
    check("R6 not yet", tx_hold, 1'b0);
    tick(1);
    check("R6 hold", tx_hold, 1'b1);
    cts_n = 1'b0; tick(2);
    check("R7 still held", tx_hold, 1'b1);
    tick(1);
    check("R7 resume", tx_hold, 1'b0);
  endtask

  task automatic t_busy();
    do_reset();
    feat_ctl = 8'h80; tx_busy = 1'b1; cts_n = 1'b1; tick(6);
    check("R6 busy waits", tx_hold, 1'b0);
    tx_busy = 1'b0; tick(1);
    check("R6 after stop bit", tx_hold, 1'b1);
  endtask

  task automatic t_clr_off();
    do_reset();
    feat_ctl = 8'h00; cts_n = 1'b1; dsr_n = 1'b1; tick(5);
    check("R8 never held", tx_hold, 1'b0);
  endtask

  task automatic t_irq();
    do_reset();
    feat_ctl = 8'h10; irq_en = 8'h80; cts_n = 1'b1; tick(3);
    check("R9 clear status", fc_status, 1'b1);
    check("R9 clear irq", irq, 1'b1);
    msr_rd = 1'b1; tick(1); msr_rd = 1'b0;
    check("R11 status cleared", fc_status, 1'b0);
    check("R11 irq cleared", irq, 1'b0);
    do_reset();
    feat_ctl = 8'h50; irq_en = 8'h40; mdm_ctl = 3'b001; rx_count = 9'd200;
    tick(1);
    check("R9 req not yet", fc_status, 1'b0);
    tick(1);
    check("R9 req status", fc_status, 1'b1);
    check("R9 req irq", irq, 1'b1);
  endtask

  task automatic t_gate_glb();
    do_reset();
    feat_ctl = 8'h00; irq_en = 8'hC0; cts_n = 1'b1; tick(4);
    check("R10 no status", fc_status, 1'b0);
    check("R10 no irq", irq, 1'b0);
  endtask

  task automatic t_or();
    do_reset();
    feat_ctl = 8'h10; irq_en = 8'h80; cts_n = 1'b1; tick(3);
    irq_en = 8'h40; tick(1);
    check("R12 irq masked", irq, 1'b0);
    check("R12 status kept", fc_status, 1'b1);
    irq_en = 8'h80; tick(1);
    check("R12 irq back", irq, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_manual();
    t_hyst();
    t_inert();
    t_pair();
    t_gate();
    t_busy();
    t_clr_off();
    t_irq();
    t_gate_glb();
    t_or();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule